// File: doc/BRIEF.md
# Program/Erase Busy Status Reporter

This block times the internal program and erase operations of a byte-wide nonvolatile memory. While an operation runs, it supplies the status byte that ordinary reads return. Command decoding raises a one-cycle start pulse together with the operation kind and the byte just written. The block then holds `busy_o` high for a fixed number of clock cycles, set by a parameter for each operation kind. The host supplies no timing while the operation runs.

There is no ready pin. Progress is reported inside the read data itself. Bit 7 is a polling bit whose value depends on the operation kind. Bit 6 changes state on every read strobe while the operation runs. When the timer expires, `done_o` pulses for one cycle and `busy_o` falls, so the surrounding logic returns array data on reads again. An abort input stops the running operation at once. The array storage and the command decoder sit outside this block.

Top module: `prog_erase_status`

## Requirements
- R1: After reset, `busy_o` is 0, `done_o` is 0 and `status_o` is 0x00.
- R2: A program start (`start_i`=1, `op_erase_i`=0) taken while idle holds `busy_o` high for exactly PROG_CYCLES clock cycles, starting in the cycle after the start edge.
- R3: An erase start (`op_erase_i`=1) taken while idle holds `busy_o` high for exactly ERASE_CYCLES clock cycles.
- R4: While a program runs, `status_o[7]` is the inverse of bit 7 of the `last_data_i` byte sampled at the start edge. Later changes on `last_data_i` have no effect.
- R5: While an erase runs, `status_o[7]` is 0.
- R6: While busy, each cycle with `rd_i`=1 inverts `status_o[6]` for the next cycle. With no read, `status_o[6]` holds its value.
- R7: While busy, `status_o[5:0]` are 0. While idle, `status_o` is 0x00.
- R8: `done_o` is 1 for exactly one cycle: the first cycle in which `busy_o` is 0 after a timed-out operation.
- R9: A start pulse that arrives while busy is ignored. The running operation keeps its length, its kind and its bit-7 value.
- R10: `abort_i`=1 makes `busy_o` 0 in the next cycle without raising `done_o`. Abort takes priority over a start in the same cycle.
- R11: Every operation starts with `status_o[6]`=0, whatever the toggle state left by the previous operation or by an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_erase_i | input | 1 | Operation kind at start: 1 = erase, 0 = byte program |
| last_data_i | input | 8 | Last byte written, sampled at start |
| rd_i | input | 1 | Read strobe, one per host read |
| abort_i | input | 1 | Stops the running operation |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse at timed completion |
| status_o | output | 8 | Status byte for reads while busy; 0 when idle |

## Verification
A count that is off by one shows at the ports as a busy window one cycle too long or too short. A wrong latched kind or latched data bit corrupts bit 7 on the first busy cycle. A toggle state that is not cleared shows as bit 6 starting at 1 on the next operation. A read strobe that is lost or counted twice breaks the alternation in the very next cycle. The bench compares every busy cycle against its own model, so each of these faults surfaces within one cycle of its cause.

// File: rtl/pes_pkg.sv
package pes_pkg;

  // Busy length in cycles for the given operation kind.
  function automatic int unsigned op_len(input logic is_erase,
                                         input int unsigned prog_n,
                                         input int unsigned erase_n);
    return is_erase ? erase_n : prog_n;
  endfunction

  // Polling bit: 0 while erasing, inverse of the written bit while programming.
  function automatic logic poll_bit(input logic is_erase, input logic d7);
    return is_erase ? 1'b0 : ~d7;
  endfunction

endpackage

// File: rtl/pes_timer.sv
module pes_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  input  logic          abort_i,
  output logic          busy_o,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;
  logic          expire;

  // Last cycle of a timed operation.
  assign expire = busy_o && (cnt_q == '0) && !abort_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_o <= expire;
      if (abort_i) begin
        busy_o <= 1'b0;
        cnt_q  <= '0;
      end else if (load_i) begin
        busy_o <= 1'b1;
        cnt_q  <= len_i - 1'b1;
      end else if (expire) begin
        busy_o <= 1'b0;
      end else if (busy_o) begin
        cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cnt_q != '0 && !abort_i) |=> (busy_o && cnt_q == $past(cnt_q) - 1'b1));

  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!busy_o && !done_o));

  p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

endmodule

// File: rtl/pes_status.sv
module pes_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic       erase_i,
  input  logic       d7_i,
  input  logic       rd_i,
  input  logic       abort_i,
  input  logic       busy_i,
  output logic [7:0] status_o
);
  logic erase_q;
  logic d7_q;
  logic tog_q;
  logic flip;

  // A read during a running operation flips the toggle bit.
  assign flip = busy_i && rd_i && !abort_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_q <= 1'b0;
      d7_q    <= 1'b0;
      tog_q   <= 1'b0;
    end else if (abort_i) begin
      tog_q   <= 1'b0;
    end else if (load_i) begin
      erase_q <= erase_i;
      d7_q    <= d7_i;
      tog_q   <= 1'b0;
    end else if (flip) begin
      tog_q   <= ~tog_q;
    end
  end

  assign status_o = busy_i ? {pes_pkg::poll_bit(erase_q, d7_q), tog_q, 6'b0} : 8'h00;

  p_tog_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flip && !load_i) |=> (tog_q != $past(tog_q)));

  p_kind_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && $past(busy_i) && !$past(load_i)) |-> ($stable(erase_q) && $stable(d7_q)));

  p_fresh_tog_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !abort_i) |=> !tog_q);

endmodule

// File: rtl/prog_erase_status.sv
module prog_erase_status #(
  parameter int PROG_CYCLES  = 1750,
  parameter int ERASE_CYCLES = 5000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       op_erase_i,
  input  logic [7:0] last_data_i,
  input  logic       rd_i,
  input  logic       abort_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] status_o
);
  localparam int MAXC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  logic          start_ok;
  logic [CW-1:0] len;

  // A start is taken only when idle and not aborted.
  assign start_ok = start_i && !busy_o && !abort_i;
  assign len      = CW'(pes_pkg::op_len(op_erase_i, PROG_CYCLES, ERASE_CYCLES));

  pes_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (start_ok),
    .len_i   (len),
    .abort_i (abort_i),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  pes_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (start_ok),
    .erase_i  (op_erase_i),
    .d7_i     (last_data_i[7]),
    .rd_i     (rd_i),
    .abort_i  (abort_i),
    .busy_i   (busy_o),
    .status_o (status_o)
  );

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> busy_o);

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(busy_o)) |-> (status_o == 8'h00));

endmodule

// File: tb/prog_erase_status_bench.sv
module prog_erase_status_bench;
  localparam int PERIOD = 10;
  localparam int PN = 6;
  localparam int EN = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, op_erase_i = 1'b0, rd_i = 1'b0, abort_i = 1'b0;
  logic [7:0] last_data_i = 8'h00;
  logic busy_o, done_o;
  logic [7:0] status_o;

  int n_run = 0;
  int n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  prog_erase_status #(.PROG_CYCLES(PN), .ERASE_CYCLES(EN)) u_prog_erase_status (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
    .last_data_i(last_data_i), .rd_i(rd_i), .abort_i(abort_i),
    .busy_o(busy_o), .done_o(done_o), .status_o(status_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {erase, data, reads}
  typedef struct packed { logic er; logic [7:0] d; logic [7:0] nr; } vec_t;
  localparam vec_t VECS [5] = '{
    '{1'b0, 8'h80, 8'd3},
    '{1'b0, 8'h35, 8'd0},
    '{1'b1, 8'hFF, 8'd5},
    '{1'b1, 8'h00, 8'd2},
    '{1'b0, 8'h7F, 8'd6}
  };

  // Runs one operation from an idle state; poke injects a start while busy (R9).
  task automatic run_op(input logic er, input logic [7:0] d, input int nr, input logic poke);
    int cyc = 0;
    logic tog = 1'b0;
    logic b7 = er ? 1'b0 : ~d[7];
    int len = er ? EN : PN;
    @(negedge clk);
    start_i = 1'b1; op_erase_i = er; last_data_i = d;
    @(negedge clk);
    start_i = 1'b0; last_data_i = ~d; op_erase_i = ~er;
    while (busy_o && cyc < 1000) begin
      chk(er ? "R5 bit7" : "R4 bit7", status_o[7], b7);
      chk(cyc == 0 ? "R11 bit6 start" : "R6 bit6", status_o[6], tog);
      chk("R7 low bits", status_o[5:0], 0);
      chk("R8 no early done", done_o, 0);
      rd_i = (cyc < nr);
      start_i = poke && (cyc == 1);
      if (start_i) begin op_erase_i = ~er; last_data_i = ~d; end
      @(negedge clk);
      if (rd_i) tog = ~tog;
      rd_i = 1'b0; start_i = 1'b0;
      cyc++;
    end
    chk(er ? "R3 busy length" : "R2 busy length", cyc, len);
    if (poke) chk("R9 length kept", cyc, len);
    chk("R8 done pulse", done_o, 1);
    chk("R7 idle status", status_o, 0);
    @(negedge clk);
    chk("R8 done one cycle", done_o, 0);
  endtask

  initial begin
    #(PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 2 + 1);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 status", status_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VECS[i]) run_op(VECS[i].er, VECS[i].d, int'(VECS[i].nr), 1'b0);

    // R9: start while busy ignored
    run_op(1'b0, 8'h00, 1, 1'b1);

    // R10: abort mid-operation after an odd number of reads
    @(negedge clk);
    start_i = 1'b1; op_erase_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    chk("R6 toggled before abort", status_o[6], 1);
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    chk("R10 busy cleared", busy_o, 0);
    chk("R10 no done", done_o, 0);
    @(negedge clk);
    chk("R10 no done later", done_o, 0);

    // R10: abort beats a simultaneous start
    start_i = 1'b1; abort_i = 1'b1; op_erase_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0; abort_i = 1'b0;
    chk("R10 abort over start", busy_o, 0);

    // R11: fresh toggle after abort
    run_op(1'b0, 8'hC3, 2, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule